// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block sits between memory clients and the memory system and remaps client addresses through a one-level page table held in memory. Each 4 KiB page of a programmable aperture has one 64-bit entry. The entry holds the physical page number and a small set of attribute and permission bits. A request that needs an entry not yet cached stalls the request port. The block then reads the entry through its own memory read port and answers once the entry arrives. A four-entry fully associative cache with round-robin replacement keeps recently used entries, so repeated accesses to the same page answer in one cycle.

Software programs the block through a small indexed register file. The registers cover the enables, the table base, the aperture bounds, a default redirect address and a pass-through window. They also include a fault register and an invalidate control used to flush the cache. Addresses inside the pass-through window, addresses outside the aperture, and all traffic while translation is off go through unchanged. A missing entry or a permission violation sends the access to the default address.

Top module: `flatpt_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, mem_rd_valid and fault are 0, and register index 0 reads 0.
- R2: Unless both the block enable (control bit 0) and the table enable (control bit 1) are set, an accepted request answers one cycle later with rsp_kind 0 (pass), rsp_addr equal to the request address zero-extended, and no memory read.
- R3: With translation on, an address inside the pass-through window (index 5 low, index 6 high, inclusive) passes through unchanged, even when it also lies inside the aperture.
- R4: With translation on, an address outside the aperture (index 2 start, index 3 end, inclusive) passes through unchanged with no memory read.
- R5: On a cache miss the entry is read from table base (index 1) plus ((address − aperture start) >> 12) × 8. mem_rd_valid and mem_rd_addr are held until mem_rd_ready, and req_ready stays low until the response.
- R6: For a valid entry (bit 0) with the needed permission, rsp_kind is 1 and rsp_addr is entry bits [39:12] above request bits [11:0]. rsp_system is entry bit 1 and rsp_snoop is entry bit 2. The response comes in the cycle after the entry data.
- R7: An entry with bit 0 clear redirects the access to the default address (index 4) with rsp_kind 2. It is not cached, so a repeat access reads memory again, and it raises no fault.
- R8: A read needs entry bit 5 and a write needs entry bit 6. A violation answers with the default address and rsp_kind 2 and sets the sticky fault output. Register index 7 then reads the faulting address in its low bits and the flag in bit 63. Any write to index 7 clears the fault.
- R9: A request whose page is cached answers one cycle after acceptance with no memory read.
- R10: Valid entries fill four cache slots in round-robin order, so a fifth distinct page evicts the oldest fill.
- R11: Writing control bit 2 as 1 flushes nothing. A later control write with bit 2 at 0 flushes every cached entry.
- R12: Indices 1 to 6 read back the written values. Indices 8 to 15 read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_widx | input | 4 | Register write index |
| reg_wdata | input | 64 | Register write data |
| reg_ridx | input | 4 | Register read index |
| reg_rdata | output | 64 | Register read data (combinational) |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Client address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 40 | Resulting physical address |
| rsp_kind | output | 2 | 0 pass, 1 translated, 2 default |
| rsp_system | output | 1 | Entry marks system memory |
| rsp_snoop | output | 1 | Entry marks snooped access |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 40 | Entry byte address |
| mem_rdata_valid | input | 1 | Entry data strobe |
| mem_rdata | input | 64 | Entry data |
| fault | output | 1 | Sticky permission fault |

## Verification
The assertions assume that memory returns exactly one data strobe for each accepted entry read, and only after that read. They assume registers are not rewritten while a miss is outstanding, and that responses are never back-pressured. The bench memory model only answers a completed handshake, with a fixed two-cycle data latency and a programmable ready delay. All register programming happens between requests, when the block is idle. A behavioural model of the cache and the fault flag predicts each response's latency, kind and address, and also predicts the entry-read count.

// File: rtl/flatpt_pkg.sv
package flatpt_pkg;
   typedef enum logic [1:0] {
      KIND_PASS = 2'd0,
      KIND_XLAT = 2'd1,
      KIND_DFLT = 2'd2
   } xkind_e;

   localparam int PAGE_SHIFT = 12;
   localparam int PTE_BYTES_SHIFT = 3;

   // entry bit positions
   localparam int PTE_V   = 0;
   localparam int PTE_SYS = 1;
   localparam int PTE_SNP = 2;
   localparam int PTE_RD  = 5;
   localparam int PTE_WR  = 6;

   // register indices
   localparam int IDX_CTRL  = 0;
   localparam int IDX_BASE  = 1;
   localparam int IDX_APLO  = 2;
   localparam int IDX_APHI  = 3;
   localparam int IDX_DFLT  = 4;
   localparam int IDX_SYLO  = 5;
   localparam int IDX_SYHI  = 6;
   localparam int IDX_FAULT = 7;

   // control bits
   localparam int CTRL_BLK = 0;
   localparam int CTRL_TBL = 1;
   localparam int CTRL_INV = 2;

   localparam int FAULT_FLAG_BIT = 63;
endpackage

// File: rtl/flatpt_regs.sv
module flatpt_regs
   import flatpt_pkg::*;
#(
   parameter int VA_W = 32,
   parameter int PA_W = 40,
   parameter int RA_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [RA_W-1:0] wr_idx,
   input  logic [63:0]     wr_data,
   input  logic [RA_W-1:0] rd_idx,
   output logic [63:0]     rd_data,
   input  logic            fault_set,
   input  logic [VA_W-1:0] fault_va,
   output logic            xlat_on,
   output logic [PA_W-1:0] tbl_base,
   output logic [PA_W-1:0] dflt_addr,
   output logic [VA_W-1:0] aper_lo,
   output logic [VA_W-1:0] aper_hi,
   output logic [VA_W-1:0] sys_lo,
   output logic [VA_W-1:0] sys_hi,
   output logic            flush,
   output logic            fault
);
   logic            blk_en_q, tbl_en_q, inv_q, flt_q;
   logic [PA_W-1:0] base_q, dflt_q;
   logic [VA_W-1:0] alo_q, ahi_q, slo_q, shi_q, fva_q;
   logic            wr_ctrl, clr_fault;

   assign wr_ctrl   = wr_en && (wr_idx == RA_W'(IDX_CTRL));
   assign clr_fault = wr_en && (wr_idx == RA_W'(IDX_FAULT));
   assign flush     = wr_ctrl && inv_q && !wr_data[CTRL_INV];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_en_q <= 1'b0;
         tbl_en_q <= 1'b0;
         inv_q    <= 1'b0;
         base_q   <= '0;
         dflt_q   <= '0;
         alo_q    <= '0;
         ahi_q    <= '0;
         slo_q    <= '0;
         shi_q    <= '0;
      end else if (wr_en) begin
         case (wr_idx)
            RA_W'(IDX_CTRL): begin
               blk_en_q <= wr_data[CTRL_BLK];
               tbl_en_q <= wr_data[CTRL_TBL];
               inv_q    <= wr_data[CTRL_INV];
            end
            RA_W'(IDX_BASE): base_q <= wr_data[PA_W-1:0];
            RA_W'(IDX_APLO): alo_q  <= wr_data[VA_W-1:0];
            RA_W'(IDX_APHI): ahi_q  <= wr_data[VA_W-1:0];
            RA_W'(IDX_DFLT): dflt_q <= wr_data[PA_W-1:0];
            RA_W'(IDX_SYLO): slo_q  <= wr_data[VA_W-1:0];
            RA_W'(IDX_SYHI): shi_q  <= wr_data[VA_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flt_q <= 1'b0;
         fva_q <= '0;
      end else if (fault_set) begin
         flt_q <= 1'b1;
         fva_q <= fault_va;
      end else if (clr_fault) begin
         flt_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         RA_W'(IDX_CTRL):  rd_data = 64'({inv_q, tbl_en_q, blk_en_q});
         RA_W'(IDX_BASE):  rd_data = 64'(base_q);
         RA_W'(IDX_APLO):  rd_data = 64'(alo_q);
         RA_W'(IDX_APHI):  rd_data = 64'(ahi_q);
         RA_W'(IDX_DFLT):  rd_data = 64'(dflt_q);
         RA_W'(IDX_SYLO):  rd_data = 64'(slo_q);
         RA_W'(IDX_SYHI):  rd_data = 64'(shi_q);
         RA_W'(IDX_FAULT): begin
            rd_data = 64'(fva_q);
            rd_data[FAULT_FLAG_BIT] = flt_q;
         end
         default: rd_data = '0;
      endcase
   end

   assign xlat_on   = blk_en_q && tbl_en_q;
   assign tbl_base  = base_q;
   assign dflt_addr = dflt_q;
   assign aper_lo   = alo_q;
   assign aper_hi   = ahi_q;
   assign sys_lo    = slo_q;
   assign sys_hi    = shi_q;
   assign fault     = flt_q;

   // R8: fault stays set until a clearing write
   p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q && !clr_fault) |=> flt_q);
endmodule

// File: rtl/flatpt_decode.sv
module flatpt_decode
   import flatpt_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 40,
   parameter int IDX_W = VA_W - PAGE_SHIFT
) (
   input  logic [VA_W-1:0]  va,
   input  logic             xlat_on,
   input  logic [VA_W-1:0]  aper_lo,
   input  logic [VA_W-1:0]  aper_hi,
   input  logic [VA_W-1:0]  sys_lo,
   input  logic [VA_W-1:0]  sys_hi,
   input  logic [PA_W-1:0]  tbl_base,
   output logic             need_xlat,
   output logic [IDX_W-1:0] page_idx,
   output logic [PA_W-1:0]  pte_addr
);
   logic            in_sys, in_ap;
   logic [VA_W-1:0] rel;

   assign in_sys    = (va >= sys_lo) && (va <= sys_hi);
   assign in_ap     = (va >= aper_lo) && (va <= aper_hi);
   assign need_xlat = xlat_on && in_ap && !in_sys;
   assign rel       = va - aper_lo;
   assign page_idx  = rel[VA_W-1:PAGE_SHIFT];
   assign pte_addr  = tbl_base + (PA_W'(page_idx) << PTE_BYTES_SHIFT);
endmodule

// File: rtl/flatpt_tlb.sv
module flatpt_tlb #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 20,
   parameter int DATA_W  = 32,
   localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);
   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [DATA_W-1:0]  dat_q [ENTRIES];
   logic [PTR_W-1:0]   rr_q;
   logic [ENTRIES-1:0] hit_vec;

   initial begin
      assert (ENTRIES >= 2) else $error("flatpt_tlb: ENTRIES must be at least 2");
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
   end

   always_comb begin
      lk_data = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) lk_data = lk_data | dat_q[i];
      end
   end
   assign lk_hit = |hit_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else if (flush) begin
         vld_q <= '0;
         rr_q  <= '0;
      end else if (fill_en) begin
         vld_q[rr_q] <= 1'b1;
         rr_q <= (rr_q == PTR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         tag_q[rr_q] <= fill_tag;
         dat_q[rr_q] <= fill_data;
      end
   end

   // R9: at most one slot matches a tag
   p_single_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
   // R11: nothing hits right after a flush
   p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));
endmodule

// File: rtl/flatpt_xlate.sv
module flatpt_xlate
   import flatpt_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PA_W        = 40,
   parameter int TLB_ENTRIES = 4,
   parameter int RA_W        = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [RA_W-1:0] reg_widx,
   input  logic [63:0]     reg_wdata,
   input  logic [RA_W-1:0] reg_ridx,
   output logic [63:0]     reg_rdata,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_addr,
   input  logic            req_write,
   output logic            rsp_valid,
   output logic [PA_W-1:0] rsp_addr,
   output logic [1:0]      rsp_kind,
   output logic            rsp_system,
   output logic            rsp_snoop,
   output logic            mem_rd_valid,
   input  logic            mem_rd_ready,
   output logic [PA_W-1:0] mem_rd_addr,
   input  logic            mem_rdata_valid,
   input  logic [63:0]     mem_rdata,
   output logic            fault
);
   localparam int IDX_W   = VA_W - PAGE_SHIFT;
   localparam int PPN_W   = PA_W - PAGE_SHIFT;
   localparam int TDATA_W = PPN_W + 4;

   initial begin
      assert (PA_W > PAGE_SHIFT && PA_W <= 64) else $error("flatpt_xlate: bad PA_W");
      assert (VA_W > PAGE_SHIFT && VA_W <= PA_W) else $error("flatpt_xlate: bad VA_W");
      assert (RA_W >= 4) else $error("flatpt_xlate: RA_W too small");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT} st_e;
   st_e state_q;

   logic            xlat_on, flush;
   logic [PA_W-1:0] tbl_base, dflt_addr;
   logic [VA_W-1:0] aper_lo, aper_hi, sys_lo, sys_hi;
   logic            need_xlat;
   logic [IDX_W-1:0] page_idx;
   logic [PA_W-1:0] pte_addr;
   logic            tlb_hit;
   logic [TDATA_W-1:0] tlb_data;

   logic [VA_W-1:0] va_q;
   logic            wr_q;
   logic [IDX_W-1:0] idx_q;
   logic [PA_W-1:0] paddr_q;

   logic            fire, use_mem, res_go, fault_set;
   logic [VA_W-1:0] e_va;
   logic            e_wr, e_xl, e_valid, e_sys, e_snp, e_rd, e_wp, perm_bad;
   logic [PPN_W-1:0] e_ppn;
   logic [PA_W-1:0] res_addr;
   xkind_e          res_kind;
   logic            fill_en;
   logic [TDATA_W-1:0] fill_data;

   logic            rsp_valid_q, rsp_sys_q, rsp_snp_q;
   logic [PA_W-1:0] rsp_addr_q;
   xkind_e          rsp_kind_q;

   flatpt_regs #(.VA_W(VA_W), .PA_W(PA_W), .RA_W(RA_W)) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_we), .wr_idx(reg_widx), .wr_data(reg_wdata),
      .rd_idx(reg_ridx), .rd_data(reg_rdata),
      .fault_set(fault_set), .fault_va(e_va),
      .xlat_on(xlat_on), .tbl_base(tbl_base), .dflt_addr(dflt_addr),
      .aper_lo(aper_lo), .aper_hi(aper_hi), .sys_lo(sys_lo), .sys_hi(sys_hi),
      .flush(flush), .fault(fault)
   );

   flatpt_decode #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)) dec_i (
      .va(req_addr), .xlat_on(xlat_on),
      .aper_lo(aper_lo), .aper_hi(aper_hi), .sys_lo(sys_lo), .sys_hi(sys_hi),
      .tbl_base(tbl_base),
      .need_xlat(need_xlat), .page_idx(page_idx), .pte_addr(pte_addr)
   );

   flatpt_tlb #(.ENTRIES(TLB_ENTRIES), .TAG_W(IDX_W), .DATA_W(TDATA_W)) tlb_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .lk_tag(page_idx), .lk_hit(tlb_hit), .lk_data(tlb_data),
      .fill_en(fill_en), .fill_tag(idx_q), .fill_data(fill_data)
   );

   assign req_ready    = (state_q == ST_IDLE);
   assign fire         = req_valid && req_ready;
   assign mem_rd_valid = (state_q == ST_FETCH);
   assign mem_rd_addr  = paddr_q;
   assign use_mem      = (state_q == ST_WAIT) && mem_rdata_valid;
   assign res_go       = use_mem || (fire && (!need_xlat || tlb_hit));

   // select the entry source: memory data on a fill, cache otherwise
   always_comb begin
      if (use_mem) begin
         e_va    = va_q;
         e_wr    = wr_q;
         e_xl    = 1'b1;
         e_valid = mem_rdata[PTE_V];
         e_ppn   = mem_rdata[PA_W-1:PAGE_SHIFT];
         e_sys   = mem_rdata[PTE_SYS];
         e_snp   = mem_rdata[PTE_SNP];
         e_rd    = mem_rdata[PTE_RD];
         e_wp    = mem_rdata[PTE_WR];
      end else begin
         e_va    = req_addr;
         e_wr    = req_write;
         e_xl    = need_xlat;
         e_valid = 1'b1;
         e_ppn   = tlb_data[TDATA_W-1:4];
         e_sys   = tlb_data[3];
         e_snp   = tlb_data[2];
         e_rd    = tlb_data[1];
         e_wp    = tlb_data[0];
      end
   end

   assign perm_bad  = e_xl && e_valid && (e_wr ? !e_wp : !e_rd);
   assign fault_set = res_go && perm_bad;

   always_comb begin
      if (!e_xl) begin
         res_kind = KIND_PASS;
         res_addr = PA_W'(e_va);
      end else if (!e_valid || perm_bad) begin
         res_kind = KIND_DFLT;
         res_addr = dflt_addr;
      end else begin
         res_kind = KIND_XLAT;
         res_addr = {e_ppn, e_va[PAGE_SHIFT-1:0]};
      end
   end

   assign fill_en   = use_mem && mem_rdata[PTE_V];
   assign fill_data = {mem_rdata[PA_W-1:PAGE_SHIFT], mem_rdata[PTE_SYS],
                       mem_rdata[PTE_SNP], mem_rdata[PTE_RD], mem_rdata[PTE_WR]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         va_q    <= '0;
         wr_q    <= 1'b0;
         idx_q   <= '0;
         paddr_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (fire && need_xlat && !tlb_hit) begin
                  va_q    <= req_addr;
                  wr_q    <= req_write;
                  idx_q   <= page_idx;
                  paddr_q <= pte_addr;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: if (mem_rd_ready) state_q <= ST_WAIT;
            ST_WAIT:  if (mem_rdata_valid) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_addr_q  <= '0;
         rsp_kind_q  <= KIND_PASS;
         rsp_sys_q   <= 1'b0;
         rsp_snp_q   <= 1'b0;
      end else begin
         rsp_valid_q <= res_go;
         if (res_go) begin
            rsp_addr_q <= res_addr;
            rsp_kind_q <= res_kind;
            rsp_sys_q  <= (res_kind == KIND_XLAT) && e_sys;
            rsp_snp_q  <= (res_kind == KIND_XLAT) && e_snp;
         end
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_addr   = rsp_addr_q;
   assign rsp_kind   = rsp_kind_q;
   assign rsp_system = rsp_sys_q;
   assign rsp_snoop  = rsp_snp_q;

   // R5: the entry read holds until accepted
   p_fetch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
   // R5: requests stall while an entry read is pending
   p_busy_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> !req_ready);
   // R9: a cached page answers on the next cycle
   p_hit_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && need_xlat && tlb_hit) |=> rsp_valid);
   // R2: with translation off every request passes on the next cycle
   p_pass_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !xlat_on) |=> (rsp_valid && rsp_kind == KIND_PASS));
endmodule

// File: tb/flatpt_xlate_tb.sv
`timescale 1ns/1ps
module flatpt_xlate_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_widx = '0;
   logic [63:0] reg_wdata = '0;
   logic [3:0]  reg_ridx = '0;
   logic [63:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [39:0] rsp_addr;
   logic [1:0]  rsp_kind;
   logic        rsp_system, rsp_snoop;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [39:0] mem_rd_addr;
   logic        mem_rdata_valid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        fault;

   always #2.5 clk = ~clk;

   flatpt_xlate dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_widx(reg_widx), .reg_wdata(reg_wdata),
      .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind),
      .rsp_system(rsp_system), .rsp_snoop(rsp_snoop),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rdata_valid(mem_rdata_valid),
      .mem_rdata(mem_rdata), .fault(fault)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // bench memory and its bookkeeping
   logic [63:0] ptmem [longint];
   int          ready_delay = 0;
   int          n_reads = 0;
   logic [39:0] last_rd_addr = '0;

   // behavioural model state
   bit          m_blk = 0, m_tbl = 0, m_inv = 0;
   logic [39:0] m_base = '0, m_dflt = '0;
   logic [31:0] m_alo = '0, m_ahi = '0, m_slo = '0, m_shi = '0;
   longint      m_tag [4];
   bit          m_vld [4];
   int          m_rr = 0;
   bit          m_fault = 0;
   logic [31:0] m_fva = '0;

   task automatic chk(input string rq, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // memory responder: ready after ready_delay cycles, data two cycles later
   initial begin
      int wcnt = 0;
      int pend = 0;
      logic [39:0] paddr = '0;
      forever begin
         @(negedge clk);
         mem_rdata_valid = 1'b0;
         mem_rd_ready = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rdata_valid = 1'b1;
               mem_rdata = ptmem.exists(longint'(paddr)) ? ptmem[longint'(paddr)] : 64'h0;
            end
         end else if (mem_rd_valid) begin
            if (wcnt >= ready_delay) begin
               mem_rd_ready = 1'b1;
               paddr = mem_rd_addr;
               last_rd_addr = mem_rd_addr;
               n_reads++;
               pend = 2;
               wcnt = 0;
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic wreg(input int idx, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_widx = 4'(idx); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      case (idx)
         0: begin
            if (m_inv && !d[2]) begin
               for (int i = 0; i < 4; i++) m_vld[i] = 0;
               m_rr = 0;
            end
            m_blk = d[0]; m_tbl = d[1]; m_inv = d[2];
         end
         1: m_base = d[39:0];
         2: m_alo = d[31:0];
         3: m_ahi = d[31:0];
         4: m_dflt = d[39:0];
         5: m_slo = d[31:0];
         6: m_shi = d[31:0];
         7: m_fault = 0;
         default: ;
      endcase
   endtask

   task automatic rreg(input int idx, output logic [63:0] v);
      @(negedge clk);
      reg_ridx = 4'(idx);
      #1 v = reg_rdata;
   endtask

   task automatic do_req(input logic [31:0] va, input bit wr, input string rq);
      int exp_lat, lat, reads0, hit_slot;
      logic [1:0]  ek;
      logic [39:0] ea, eaddr;
      logic [63:0] pte;
      bit esys, esnp, miss;
      longint idx;
      esys = 0; esnp = 0; miss = 0; eaddr = '0; pte = '0;
      if (!(m_blk && m_tbl) || (va >= m_slo && va <= m_shi) || !(va >= m_alo && va <= m_ahi)) begin
         ek = 2'd0; ea = {8'h0, va}; exp_lat = 1;
      end else begin
         idx = longint'((va - m_alo) >> 12);
         eaddr = m_base + 40'(idx * 8);
         pte = ptmem.exists(longint'(eaddr)) ? ptmem[longint'(eaddr)] : 64'h0;
         hit_slot = -1;
         for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == idx) hit_slot = i;
         miss = (hit_slot < 0);
         exp_lat = miss ? 4 + ready_delay : 1;
         if (miss && pte[0]) begin
            m_vld[m_rr] = 1; m_tag[m_rr] = idx; m_rr = (m_rr + 1) % 4;
         end
         if (!pte[0]) begin
            ek = 2'd2; ea = m_dflt;
         end else if (wr ? !pte[6] : !pte[5]) begin
            ek = 2'd2; ea = m_dflt; m_fault = 1; m_fva = va;
         end else begin
            ek = 2'd1; ea = {pte[39:12], va[11:0]}; esys = pte[1]; esnp = pte[2];
         end
      end
      reads0 = n_reads;
      @(negedge clk);
      chk(rq, "req_ready", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_addr = va; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      chk(rq, "latency", 64'(lat), 64'(exp_lat));
      chk(rq, "rsp_kind", 64'(rsp_kind), 64'(ek));
      chk(rq, "rsp_addr", 64'(rsp_addr), 64'(ea));
      chk(rq, "rsp_system", 64'(rsp_system), 64'(esys));
      chk(rq, "rsp_snoop", 64'(rsp_snoop), 64'(esnp));
      chk(rq, "entry reads", 64'(n_reads - reads0), 64'(miss ? 1 : 0));
      if (miss) chk(rq, "entry address", 64'(last_rd_addr), 64'(eaddr));
      chk(rq, "fault", 64'(fault), 64'(m_fault));
   endtask

   function automatic logic [63:0] pg_pte(input int i, input logic [7:0] flags);
      return 64'h0000_0077_0000_0000 + (64'(i) << 12) + 64'(flags);
   endfunction

   localparam logic [39:0] TB_BASE = 40'h00_1234_0000;
   localparam logic [31:0] TB_ALO  = 32'h1000_0000;

   function automatic logic [31:0] pva(input int i, input int off);
      return TB_ALO + 32'(i * 4096) + 32'(off);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      logic [63:0] v;
      for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
      for (int i = 0; i < 6; i++) ptmem[longint'(TB_BASE + 40'(i * 8))] = pg_pte(i, 8'h61);
      ptmem[longint'(TB_BASE + 40'd8)]  = pg_pte(1, 8'h67);
      ptmem[longint'(TB_BASE + 40'd48)] = pg_pte(6, 8'h21);
      ptmem[longint'(TB_BASE + 40'd56)] = pg_pte(7, 8'h60);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "req_ready", 64'(req_ready), 64'd1);
      chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R1", "mem_rd_valid", 64'(mem_rd_valid), 64'd0);
      chk("R1", "fault", 64'(fault), 64'd0);
      rreg(0, v); chk("R1", "ctrl", v, 64'd0);

      // R12 programming and readback
      wreg(1, 64'(TB_BASE));
      wreg(2, 64'(TB_ALO));
      wreg(3, 64'h1FFF_FFFF);
      wreg(4, 64'h00DE_AD00_0000);
      wreg(5, 64'h1800_0000);
      wreg(6, 64'h18FF_FFFF);
      rreg(1, v); chk("R12", "base", v, 64'(TB_BASE));
      rreg(3, v); chk("R12", "aperture end", v, 64'h1FFF_FFFF);
      rreg(4, v); chk("R12", "default", v, 64'h00DE_AD00_0000);
      wreg(9, 64'hFFFF_FFFF_FFFF_FFFF);
      rreg(9, v); chk("R12", "context 9", v, 64'd0);
      rreg(0, v); chk("R12", "ctrl untouched", v, 64'd0);
      rreg(14, v); chk("R12", "context 14", v, 64'd0);

      // R2 translation off
      do_req(pva(0, 'h10), 0, "R2");
      wreg(0, 64'h1);
      do_req(pva(2, 'h20), 1, "R2");
      wreg(0, 64'h3);

      // R3 pass-through window overrides the aperture, R4 outside aperture
      do_req(32'h1800_4321, 0, "R3");
      do_req(32'h3000_0044, 1, "R4");
      do_req(32'h0FFF_FFFF, 0, "R4");

      // R5/R6 miss then R9 hit
      do_req(pva(0, 'h123), 0, "R6");
      do_req(pva(0, 'hFFC), 1, "R9");
      ready_delay = 3;
      do_req(pva(1, 'h008), 0, "R5");
      ready_delay = 0;
      do_req(pva(1, 'h800), 1, "R9");

      // R7 invalid entry, fetched again
      do_req(pva(7, 'h0), 0, "R7");
      do_req(pva(7, 'h4), 0, "R7");

      // R8 permission fault
      do_req(pva(6, 'h40), 1, "R8");
      rreg(7, v); chk("R8", "fault register", v, {1'b1, 31'h0, pva(6, 'h40)});
      do_req(pva(6, 'h44), 0, "R8");
      wreg(7, 64'h0);
      @(negedge clk);
      chk("R8", "fault cleared", 64'(fault), 64'd0);

      // R10 round robin: slots hold pages 0,1,6 then 2; page 3 evicts page 0
      do_req(pva(2, 'h0), 0, "R10");
      do_req(pva(3, 'h0), 0, "R10");
      do_req(pva(1, 'h10), 0, "R10");
      do_req(pva(0, 'h10), 0, "R10");

      // R11 invalidate handshake
      wreg(0, 64'h7);
      do_req(pva(3, 'h20), 0, "R11");
      wreg(0, 64'h3);
      do_req(pva(3, 'h24), 0, "R11");
      do_req(pva(3, 'h28), 1, "R11");

      done = 1;
      repeat (2) @(negedge clk);
      summary();
   end
endmodule